// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block is the software-visible register file that sits in front of a bank of up to eight DMA channel engines. A simple bus slave reads and writes 32-bit words by byte address. Three control words set each channel's transfer mode and direction, hold the per-channel interrupt enables and launch channels. One status word gathers every channel's pending-interrupt flag, error flag and live activity code. Each channel also owns four working words: device address, memory address, transfer size and link to the next descriptor.

The engines see a one-cycle start pulse per channel, a steady mode code and a direction bit. They report back through per-channel done and error strobes and a 2-bit activity code. One interrupt line is raised while any enabled channel has a pending flag. Software acknowledges flags by writing the status word back: a 1 in a bit position clears that flag. The channel count is a parameter and may be 4 or 8.

Top module: `dmx_regfile`

## Requirements
- R1: After reset every stored register reads 0, `irq` is low, and `chan_start`, `chan_mode` and `chan_dir` are all 0.
- R2: The word at byte 0x00 holds a 4-bit field per channel starting at bit 4*ch. Field bits [1:0] drive `chan_mode[2ch+1:2ch]` (0 off, 1 descriptor chain, 2 single block). Field bit 2 drives `chan_dir[ch]` (1 = memory to device). Field bit 3, and the fields of channels that are not built, read as 0.
- R3: The word at byte 0x04 is a plain 32-bit read/write register.
- R4: At byte 0x08, bits [NUM_CH-1:0] are interrupt enables that read back as written. Every other bit of this word reads as 0.
- R5: A write to byte 0x08 with bit 8+ch set, while channel ch reports activity code 0, raises `chan_start[ch]` for exactly the one cycle after the write edge. Start bits always read as 0.
- R6: A start request for a channel whose activity code is not 0 produces no pulse on that channel. Other requested idle channels in the same write still start.
- R7: `eng_done[ch]` sets the pending flag at bit ch of the status word (byte 0x10). `eng_err[ch]` sets both the error flag at bit 8+ch and the pending flag. Either flag is visible from the edge that samples the strobe.
- R8: Writing the status word clears each pending or error flag whose bit is written as 1. Flags written as 0 keep their value, and the activity field cannot be written.
- R9: When an engine strobe and a software clear hit the same flag in the same cycle, the flag ends set.
- R10: Status bits [17+2ch:16+2ch] show `eng_state[2ch+1:2ch]` directly (0 idle, 1 fetching a descriptor, 2 waiting, 3 moving data).
- R11: `irq` is high exactly when some channel has both its pending flag and its enable set.
- R12: Channel ch has four 32-bit read/write words at byte 0x20+16*ch plus 0x0, 0x4, 0x8 and 0xC.
- R13: Bytes 0x0C, 0x14, 0x18, 0x1C and every address past the last channel bank read as 0. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address (low two bits ignored) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the address |
| chan_start | output | NUM_CH | One-cycle start pulse per channel |
| chan_mode | output | 2*NUM_CH | Mode code per channel |
| chan_dir | output | NUM_CH | Direction per channel, 1 = memory to device |
| eng_done | input | NUM_CH | Completion strobe per channel |
| eng_err | input | NUM_CH | Error strobe per channel |
| eng_state | input | 2*NUM_CH | Activity code per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
A flag register that misses a set, or clears the wrong bit, shows up in the status word on the first read after the strobe or the clear. Because `irq` is built from those flags and the enables, the same fault reaches `irq` in that cycle. A faulty start path shows as a missing or extra pulse on `chan_start` one edge after the control write, so it is sampled in that single cycle and in the cycle after. A bad address decode shows as a wrong value on a read-back, or as a write to one word that also changes another word.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
   // word index (byte address / 4) of each global register
   localparam int IDX_CTL0  = 0;
   localparam int IDX_CTL1  = 1;
   localparam int IDX_CTL2  = 2;
   localparam int IDX_STS0  = 4;
   localparam int IDX_STS1  = 5;
   localparam int IDX_BANK0 = 8;

   localparam int START_LSB = 8;   // start request field in control 2
   localparam int ERR_LSB   = 8;   // error flags in status 0
   localparam int STATE_LSB = 16;  // activity codes in status 0

   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_CHAIN  = 2'd1,
      MODE_SINGLE = 2'd2
   } chan_mode_e;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_FETCH = 2'd1,
      ENG_WAIT  = 2'd2,
      ENG_XFER  = 2'd3
   } eng_state_e;
endpackage

// File: rtl/dmx_ctrl_regs.sv
module dmx_ctrl_regs
   import dmx_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DW     = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_ctl0,
   input  logic                wr_ctl1,
   input  logic                wr_ctl2,
   input  logic [DW-1:0]       wdata,
   input  logic [NUM_CH-1:0]   eng_idle,
   output logic [DW-1:0]       ctl0_rd,
   output logic [DW-1:0]       ctl1_rd,
   output logic [NUM_CH-1:0]   en_q,
   output logic [NUM_CH-1:0]   start_o,
   output logic [2*NUM_CH-1:0] mode_o,
   output logic [NUM_CH-1:0]   dir_o
);
   localparam int FLD = 4;

   logic [DW-1:0]     ctl1_q;
   logic [NUM_CH-1:0] start_q;
   logic              unused_wd;

   assign unused_wd = ^wdata;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [1:0] mode_q;
      logic       dir_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mode_q <= MODE_OFF;
            dir_q  <= 1'b0;
         end else if (wr_ctl0) begin
            mode_q <= wdata[FLD*i +: 2];
            dir_q  <= wdata[FLD*i + 2];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) start_q[i] <= 1'b0;
         else        start_q[i] <= wr_ctl2 & wdata[START_LSB+i] & eng_idle[i];
      end

      assign mode_o[2*i +: 2] = mode_q;
      assign dir_o[i]         = dir_q;

      // R5: a pulse is only ever the answer to a start request written last cycle
      p_start_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
         start_o[i] |-> $past(wr_ctl2 && wdata[START_LSB+i]));
      // R6: a pulse never goes to a channel that was busy at the write
      p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
         start_o[i] |-> $past(eng_idle[i]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl1_q <= '0;
         en_q   <= '0;
      end else begin
         if (wr_ctl1) ctl1_q <= wdata;
         if (wr_ctl2) en_q   <= wdata[NUM_CH-1:0];
      end
   end

   always_comb begin
      ctl0_rd = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         ctl0_rd[FLD*i +: 2] = mode_o[2*i +: 2];
         ctl0_rd[FLD*i + 2]  = dir_o[i];
      end
   end

   assign ctl1_rd = ctl1_q;
   assign start_o = start_q;

   // R2: engine-facing mode only moves on a control-0 write
   p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_ctl0) |-> $stable(mode_o));
endmodule

// File: rtl/dmx_irq_status.sv
module dmx_irq_status
   import dmx_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sts0,
   input  logic [DW-1:0]     wdata,
   input  logic [NUM_CH-1:0] eng_done,
   input  logic [NUM_CH-1:0] eng_err,
   input  logic [NUM_CH-1:0] en,
   output logic [NUM_CH-1:0] pend_q,
   output logic [NUM_CH-1:0] err_q,
   output logic              irq_o
);
   logic [NUM_CH-1:0] clr_pend;
   logic [NUM_CH-1:0] clr_err;
   logic              unused_wd;

   assign unused_wd = ^wdata;
   assign clr_pend  = wr_sts0 ? wdata[NUM_CH-1:0]           : '0;
   assign clr_err   = wr_sts0 ? wdata[ERR_LSB +: NUM_CH]    : '0;

   // set terms are ORed after the clear mask, so a same-cycle set survives
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         err_q  <= '0;
      end else begin
         pend_q <= (pend_q & ~clr_pend) | eng_done | eng_err;
         err_q  <= (err_q  & ~clr_err)  | eng_err;
      end
   end

   assign irq_o = |(pend_q & en);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      // R9: any engine strobe leaves the pending flag set, clear or not
      p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $past(eng_done[i] || eng_err[i]) |-> pend_q[i]);
      // R8: an uncontested write-one clears the flag
      p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $past(wr_sts0 && wdata[i] && !eng_done[i] && !eng_err[i]) |-> !pend_q[i]);
      // R7: the error flag is never set without the pending flag
      p_err_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(err_q[i]) |-> pend_q[i]);
   end
endmodule

// File: rtl/dmx_chan_bank.sv
module dmx_chan_bank #(
   parameter int NUM_CH = 8,
   parameter int DW     = 32,
   parameter int WW     = 6,
   parameter int BASE   = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [WW-1:0] widx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          hit
);
   localparam int NREG = 4 * NUM_CH;

   logic [DW-1:0] regs_q [NREG];

   for (genvar k = 0; k < NREG; k++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)                             regs_q[k] <= '0;
         else if (we && widx == WW'(BASE + k))   regs_q[k] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      hit   = 1'b0;
      for (int k = 0; k < NREG; k++) begin
         if (widx == WW'(BASE + k)) begin
            rdata = regs_q[k];
            hit   = 1'b1;
         end
      end
   end

   // R12: a bank word only changes on a write that selects it
   for (genvar k = 0; k < NREG; k++) begin : g_chk
      p_bank_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(we && widx == WW'(BASE + k)) |-> $stable(regs_q[k]));
   end
endmodule

// File: rtl/dmx_regfile.sv
module dmx_regfile
   import dmx_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int AW     = 8,
   parameter int DW     = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [AW-1:0]       bus_addr,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata,
   output logic [NUM_CH-1:0]   chan_start,
   output logic [2*NUM_CH-1:0] chan_mode,
   output logic [NUM_CH-1:0]   chan_dir,
   input  logic [NUM_CH-1:0]   eng_done,
   input  logic [NUM_CH-1:0]   eng_err,
   input  logic [2*NUM_CH-1:0] eng_state,
   output logic                irq
);
   localparam int WW = AW - 2;

   if (!(NUM_CH == 4 || NUM_CH == 8)) begin : g_bad_ch
      $error("dmx_regfile: NUM_CH must be 4 or 8");
   end
   if (DW != 32) begin : g_bad_dw
      $error("dmx_regfile: DW must be 32");
   end
   if (IDX_BANK0 + 4 * NUM_CH > (1 << WW)) begin : g_bad_aw
      $error("dmx_regfile: AW too small for the channel banks");
   end

   logic [WW-1:0]     widx;
   logic              we, unused_lsb;
   logic              wr_ctl0, wr_ctl1, wr_ctl2, wr_sts0;
   logic [NUM_CH-1:0] eng_idle, en_q, pend_q, err_q;
   logic [DW-1:0]     ctl0_rd, ctl1_rd, sts_rd, bank_rd;
   logic              bank_hit;

   assign widx       = bus_addr[AW-1:2];
   assign unused_lsb = ^bus_addr[1:0];
   assign we         = bus_sel & bus_wr;
   assign wr_ctl0    = we && (widx == WW'(IDX_CTL0));
   assign wr_ctl1    = we && (widx == WW'(IDX_CTL1));
   assign wr_ctl2    = we && (widx == WW'(IDX_CTL2));
   assign wr_sts0    = we && (widx == WW'(IDX_STS0));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_idle
      assign eng_idle[i] = (eng_state[2*i +: 2] == ENG_IDLE);
   end

   dmx_ctrl_regs #(.NUM_CH(NUM_CH), .DW(DW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctl0  (wr_ctl0),
      .wr_ctl1  (wr_ctl1),
      .wr_ctl2  (wr_ctl2),
      .wdata    (bus_wdata),
      .eng_idle (eng_idle),
      .ctl0_rd  (ctl0_rd),
      .ctl1_rd  (ctl1_rd),
      .en_q     (en_q),
      .start_o  (chan_start),
      .mode_o   (chan_mode),
      .dir_o    (chan_dir)
   );

   dmx_irq_status #(.NUM_CH(NUM_CH), .DW(DW)) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sts0  (wr_sts0),
      .wdata    (bus_wdata),
      .eng_done (eng_done),
      .eng_err  (eng_err),
      .en       (en_q),
      .pend_q   (pend_q),
      .err_q    (err_q),
      .irq_o    (irq)
   );

   dmx_chan_bank #(.NUM_CH(NUM_CH), .DW(DW), .WW(WW), .BASE(IDX_BANK0)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .widx  (widx),
      .wdata (bus_wdata),
      .rdata (bank_rd),
      .hit   (bank_hit)
   );

   always_comb begin
      sts_rd = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         sts_rd[i]                   = pend_q[i];
         sts_rd[ERR_LSB + i]         = err_q[i];
         sts_rd[STATE_LSB + 2*i +: 2] = eng_state[2*i +: 2];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if      (widx == WW'(IDX_CTL0)) bus_rdata = ctl0_rd;
      else if (widx == WW'(IDX_CTL1)) bus_rdata = ctl1_rd;
      else if (widx == WW'(IDX_CTL2)) bus_rdata = DW'(en_q);
      else if (widx == WW'(IDX_STS0)) bus_rdata = sts_rd;
      else if (bank_hit)              bus_rdata = bank_rd;
   end

   // R11: with every enable off the interrupt line stays low
   p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq);
   // R5: start request bits never appear on a control-2 read
   p_start_rd0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (widx == WW'(IDX_CTL2)) |-> (bus_rdata[START_LSB +: 8] == 8'h00));
   // R13: the second status word always reads as zero
   p_sts1_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (widx == WW'(IDX_STS1)) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_dmx_regfile.sv
`timescale 1ns/1ps
module sim_dmx_regfile;
   localparam int NCH = 8;
   localparam int NV  = 22;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]       bus_addr = '0;
   logic [31:0]      bus_wdata = '0, bus_rdata;
   logic [NCH-1:0]   chan_start, chan_dir;
   logic [2*NCH-1:0] chan_mode;
   logic [NCH-1:0]   eng_done = '0, eng_err = '0;
   logic [2*NCH-1:0] eng_state = '0;
   logic             irq;

   int  n_chk = 0, n_bad = 0;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   dmx_regfile #(.NUM_CH(NCH), .AW(8), .DW(32)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .chan_start(chan_start), .chan_mode(chan_mode), .chan_dir(chan_dir),
      .eng_done(eng_done), .eng_err(eng_err), .eng_state(eng_state), .irq(irq)
   );

   // {write, byte address, write data, expected read data}
   localparam logic [72:0] VEC [NV] = '{
      {1'b1, 8'h00, 32'h8765_4321, 32'h0},        // R2
      {1'b0, 8'h00, 32'h0, 32'h0765_4321},        // R2 bit 3 of each field reads 0
      {1'b1, 8'h04, 32'hDEAD_BEEF, 32'h0},        // R3
      {1'b0, 8'h04, 32'h0, 32'hDEAD_BEEF},        // R3
      {1'b1, 8'h08, 32'hFFFF_00A5, 32'h0},        // R4
      {1'b0, 8'h08, 32'h0, 32'h0000_00A5},        // R4
      {1'b1, 8'h20, 32'h1111_1111, 32'h0},        // R12 ch0 device address
      {1'b1, 8'h9C, 32'h2222_2222, 32'h0},        // R12 ch7 link word
      {1'b1, 8'h44, 32'h3333_3333, 32'h0},        // R12 ch2 memory address
      {1'b0, 8'h20, 32'h0, 32'h1111_1111},        // R12
      {1'b0, 8'h9C, 32'h0, 32'h2222_2222},        // R12
      {1'b0, 8'h44, 32'h0, 32'h3333_3333},        // R12
      {1'b0, 8'h48, 32'h0, 32'h0},                // R12 neighbour untouched
      {1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0},        // R13
      {1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0},        // R13
      {1'b1, 8'hA0, 32'hFFFF_FFFF, 32'h0},        // R13
      {1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0},        // R13
      {1'b0, 8'h0C, 32'h0, 32'h0},                // R13
      {1'b0, 8'h14, 32'h0, 32'h0},                // R13
      {1'b0, 8'hA0, 32'h0, 32'h0},                // R13
      {1'b0, 8'h00, 32'h0, 32'h0765_4321},        // R13 control 0 unchanged
      {1'b0, 8'h04, 32'h0, 32'hDEAD_BEEF}         // R13 control 1 unchanged
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic pulse_engine(input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
      @(negedge clk);
      eng_done = dn; eng_err = er;
      @(negedge clk);
      eng_done = '0; eng_err = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(8'h00, rd); check("R1 control0", rd, 32'h0);
      bus_read(8'h08, rd); check("R1 control2", rd, 32'h0);
      bus_read(8'h10, rd); check("R1 status0", rd, 32'h0);
      bus_read(8'h58, rd); check("R1 bank word", rd, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);
      check("R1 start", 32'(chan_start), 32'h0);
      check("R1 mode", 32'(chan_mode), 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][72]) bus_write(VEC[i][71:64], VEC[i][63:32]);
         else begin
            bus_read(VEC[i][71:64], rd);
            check($sformatf("vector %0d (R2/R3/R4/R12/R13)", i), rd, VEC[i][31:0]);
         end
      end

      // R2 engine-facing fields from nibbles 1..8
      check("R2 mode outputs", 32'(chan_mode), 32'h0000_3939);
      check("R2 dir outputs", 32'(chan_dir), 32'h0000_0078);

      // R5 start pulse on idle channels 0 and 2
      bus_write(8'h08, 32'h0000_0500);
      check("R5 start pulse", 32'(chan_start), 32'h05);
      @(negedge clk);
      check("R5 pulse one cycle", 32'(chan_start), 32'h00);
      bus_read(8'h08, rd); check("R5 start reads 0", rd, 32'h0);

      // R6 channel 1 busy: only channel 0 starts
      eng_state = 16'h0008;
      bus_write(8'h08, 32'h0000_0300);
      check("R6 busy channel ignored", 32'(chan_start), 32'h01);

      // R10 live activity codes
      eng_state = 16'hC008;
      bus_read(8'h10, rd); check("R10 state field", rd, 32'hC008_0000);
      eng_state = '0;

      // R7 / R11 flags and interrupt
      bus_write(8'h08, 32'h0);
      pulse_engine(8'h08, 8'h00);
      bus_read(8'h10, rd); check("R7 done sets pending", rd, 32'h0000_0008);
      check("R11 irq masked", {31'h0, irq}, 32'h0);
      bus_write(8'h08, 32'h0000_0008);
      check("R11 irq enabled", {31'h0, irq}, 32'h1);
      pulse_engine(8'h00, 8'h20);
      bus_read(8'h10, rd); check("R7 error sets both", rd, 32'h0000_2028);

      // R8 clear only the written-one bit
      bus_write(8'h10, 32'hFFFF_0008);
      bus_read(8'h10, rd); check("R8 write-one clear", rd, 32'h0000_2020);
      check("R11 irq after clear", {31'h0, irq}, 32'h0);

      // R9 set beats clear in the same cycle
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h0000_2060;
      eng_done = 8'h40;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; eng_done = '0;
      bus_read(8'h10, rd); check("R9 set wins", rd, 32'h0000_0040);
      bus_write(8'h08, 32'h0000_0040);
      check("R11 irq channel 6", {31'h0, irq}, 32'h1);

      finish_run();
   end
endmodule